// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a clocked single-port memory that behaves like a burst static RAM with a 36-bit word. Every control except output enable and sleep is sampled on the rising clock edge. On each edge the block does exactly one of the following:

- stays idle;
- sleeps;
- deselects;
- opens a burst at the external address;
- steps the burst to its next address;
- holds the burst at its current address, which inserts a wait state.

Two address strobes open a burst. The processor strobe always reads. The controller strobe reads or writes, as the write controls select. A write at an address opened by the processor strobe is made by asserting the write controls on the following edge.

The word is made of four 9-bit lanes, each with 8 data bits and one parity bit. Writes can be masked per lane. Read data leaves either in the same cycle as the access (flow-through) or one clock later (pipelined), as a parameter selects. A second parameter selects the burst order, linear or interleaved.

The tri-state data bus is modelled as a data output `rdata_o` plus a drive flag `rdata_oe_o`. When the flag is low, the data output reads as zero. The array depth is a parameter, so a small array can be used in simulation.

Top module: `sync_burst_sram`

## Requirements
- R1: The word has four 9-bit lanes: lane a is bits [8:0], lane b is [17:9], lane c is [26:18] and lane d is [35:27]. `lane_sel_ni` bit 0 gates lane a, bit 1 lane b, bit 2 lane c and bit 3 lane d. A write with `all_wr_ni` low writes all four lanes, whatever `lane_sel_ni` holds.
- R2: An access is a write when `all_wr_ni` is low, or when `lane_wr_ni` is low and at least one bit of `lane_sel_ni` is low. Every other access is a read; this includes `lane_wr_ni` low with `lane_sel_ni` = 4'hF.
- R3: When `cpu_strobe_ni` is low at an edge with all chip enables asserted, the block loads `addr_i` and reads. The write controls are ignored and the memory is left unchanged.
- R4: When neither strobe is low and a burst is open, write controls asserted at that edge write `wdata_i` at the burst address. A write at an address just loaded by the processor strobe is done this way.
- R5: With no strobe and `burst_step_ni` low, the burst moves to its next address. Only the low two address bits change, and in linear order they count up, wrapping from 3 to 0.
- R6: With no strobe and `burst_step_ni` high, the burst address is held and the same word is accessed again.
- R7: With INTERLEAVED=1, the n-th access of a burst uses low address bits equal to the start bits XOR n.
- R8: With PIPELINED=0, read data is driven in the cycle after the edge that makes the access. With PIPELINED=1, it is driven one clock later.
- R9: A strobe at an edge where `chip_en_ni` is high, `chip_en_i` is low or `chip_en2_ni` is high deselects the block. Outputs go undriven, and no access happens until the next enabled strobe.
- R10: While `sleep_i` is high the outputs are undriven at once, and edges make no access.
- R11: `drv_en_ni` high makes the outputs undriven without waiting for a clock. A write access never drives the outputs.
- R12: After reset no burst is open and `rdata_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External word address |
| cpu_strobe_ni | input | 1 | Processor address strobe, active low, read only |
| ctl_strobe_ni | input | 1 | Controller address strobe, active low |
| burst_step_ni | input | 1 | Low: step the burst; high: hold it |
| chip_en_ni | input | 1 | Chip enable, active low |
| chip_en_i | input | 1 | Chip enable, active high |
| chip_en2_ni | input | 1 | Second chip enable, active low |
| all_wr_ni | input | 1 | Global write, all lanes, active low |
| lane_wr_ni | input | 1 | Lane write qualifier, active low |
| lane_sel_ni | input | 4 | Per-lane write enables, active low |
| drv_en_ni | input | 1 | Output enable, asynchronous, active low |
| sleep_i | input | 1 | Snooze request, active high |
| wdata_i | input | 36 | Write data |
| rdata_o | output | 36 | Read data, zero when not driven |
| rdata_oe_o | output | 1 | High when the data bus is driven |

## Verification
On every cycle, the assertions check that sleep and output enable force the bus undriven, and that a write access never drives it. They also check that the processor strobe always decodes to a read, and that deselect and sleep make no access. Two further properties cover the burst address: it stays inside its 4-word group between loads, and it holds when the burst neither loads nor steps. Only the bench's scenarios can show the stored contents: lane masking, the ordering of a write after a processor strobe, wrap-around in linear and interleaved order, and the one-cycle latency difference between the two read modes.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_SLEEP,
    ACT_DESEL,
    ACT_LOAD,
    ACT_STEP,
    ACT_HOLD
  } act_e;

  typedef struct packed {
    act_e act;
    logic wr;
  } cmd_t;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
(
  input  logic             cpu_strobe_ni,
  input  logic             ctl_strobe_ni,
  input  logic             burst_step_ni,
  input  logic             chip_en_ni,
  input  logic             chip_en_i,
  input  logic             chip_en2_ni,
  input  logic             all_wr_ni,
  input  logic             lane_wr_ni,
  input  logic [LANES-1:0] lane_sel_ni,
  input  logic             sleep_i,
  input  logic             active_i,
  output cmd_t             cmd_o,
  output logic [LANES-1:0] lane_we_o,
  output logic             chip_sel_o
);
  logic wr_req;
  logic any_strobe;

  assign chip_sel_o = !chip_en_ni && chip_en_i && !chip_en2_ni;
  assign any_strobe = !cpu_strobe_ni || !ctl_strobe_ni;
  assign wr_req     = !all_wr_ni || (!lane_wr_ni && (lane_sel_ni != '1));
  assign lane_we_o  = !all_wr_ni ? '1 : (lane_wr_ni ? '0 : ~lane_sel_ni);

  always_comb begin
    cmd_o.act = ACT_IDLE;
    cmd_o.wr  = 1'b0;
    if (sleep_i) begin
      cmd_o.act = ACT_SLEEP;
    end else if (any_strobe && !chip_sel_o) begin
      cmd_o.act = ACT_DESEL;
    end else if (!cpu_strobe_ni) begin
      cmd_o.act = ACT_LOAD;  // processor strobe: read regardless of write controls
    end else if (!ctl_strobe_ni) begin
      cmd_o.act = ACT_LOAD;
      cmd_o.wr  = wr_req;
    end else if (active_i) begin
      cmd_o.act = burst_step_ni ? ACT_HOLD : ACT_STEP;
      cmd_o.wr  = wr_req;
    end
  end
endmodule

// File: rtl/sbs_burst.sv
module sbs_burst #(
  parameter int AW          = 6,
  parameter bit INTERLEAVED = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] acc_addr_o,
  output logic [AW-1:0] cur_addr_o
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nx;

  function automatic logic [1:0] order(input logic [1:0] start, input logic [1:0] n);
    if (INTERLEAVED) return start ^ n;
    else             return start + n;
  endfunction

  assign cnt_nx     = cnt_q + 2'd1;
  assign cur_addr_o = {base_q[AW-1:2], order(base_q[1:0], cnt_q)};

  always_comb begin
    if (load_i)      acc_addr_o = addr_i;
    else if (step_i) acc_addr_o = {base_q[AW-1:2], order(base_q[1:0], cnt_nx)};
    else             acc_addr_o = cur_addr_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_nx;
    end
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [LANES-1:0] lane_we_i,
  input  logic [AW-1:0]    waddr_i,
  input  word_t            wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output word_t            rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && lane_we_i[l]) mem_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/sbs_rdpath.sv
module sbs_rdpath
  import sbs_pkg::*;
#(
  parameter bit PIPELINED = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_fire_i,
  input  word_t arr_data_i,
  output word_t data_o,
  output logic  valid_o,
  output logic  hit_o
);
  logic hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= rd_fire_i;
  end
  assign hit_o = hit_q;

  if (PIPELINED) begin : g_pipe
    logic  pv_q;
    word_t pd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pv_q <= 1'b0;
        pd_q <= '0;
      end else begin
        pv_q <= hit_q;
        if (hit_q) pd_q <= arr_data_i;
      end
    end
    assign valid_o = pv_q;
    assign data_o  = pd_q;
  end else begin : g_flow
    assign valid_o = hit_q;
    assign data_o  = arr_data_i;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter bit PIPELINED   = 1'b0,
  parameter bit INTERLEAVED = 1'b0,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          cpu_strobe_ni,
  input  logic          ctl_strobe_ni,
  input  logic          burst_step_ni,
  input  logic          chip_en_ni,
  input  logic          chip_en_i,
  input  logic          chip_en2_ni,
  input  logic          all_wr_ni,
  input  logic          lane_wr_ni,
  input  logic [3:0]    lane_sel_ni,
  input  logic          drv_en_ni,
  input  logic          sleep_i,
  input  logic [35:0]   wdata_i,
  output logic [35:0]   rdata_o,
  output logic          rdata_oe_o
);
  cmd_t             cmd;
  logic [LANES-1:0] lane_we;
  logic             chip_sel;
  logic             active_q;
  logic             do_load, do_step, do_access, do_write;
  logic [AW-1:0]    acc_addr, cur_addr;
  word_t            arr_data, rd_data;
  logic             rd_valid, rd_hit;

  sbs_decode u_decode (
    .cpu_strobe_ni (cpu_strobe_ni),
    .ctl_strobe_ni (ctl_strobe_ni),
    .burst_step_ni (burst_step_ni),
    .chip_en_ni    (chip_en_ni),
    .chip_en_i     (chip_en_i),
    .chip_en2_ni   (chip_en2_ni),
    .all_wr_ni     (all_wr_ni),
    .lane_wr_ni    (lane_wr_ni),
    .lane_sel_ni   (lane_sel_ni),
    .sleep_i       (sleep_i),
    .active_i      (active_q),
    .cmd_o         (cmd),
    .lane_we_o     (lane_we),
    .chip_sel_o    (chip_sel)
  );

  assign do_load   = cmd.act == ACT_LOAD;
  assign do_step   = cmd.act == ACT_STEP;
  assign do_access = do_load || do_step || cmd.act == ACT_HOLD;
  assign do_write  = do_access && cmd.wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  active_q <= 1'b0;
    else if (do_load)             active_q <= 1'b1;
    else if (cmd.act == ACT_DESEL) active_q <= 1'b0;
  end

  sbs_burst #(.AW(AW), .INTERLEAVED(INTERLEAVED)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (do_load),
    .step_i     (do_step),
    .addr_i     (addr_i),
    .acc_addr_o (acc_addr),
    .cur_addr_o (cur_addr)
  );

  sbs_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk_i     (clk_i),
    .we_i      (do_write),
    .lane_we_i (lane_we),
    .waddr_i   (acc_addr),
    .wdata_i   (wdata_i),
    .raddr_i   (cur_addr),
    .rdata_o   (arr_data)
  );

  sbs_rdpath #(.PIPELINED(PIPELINED)) u_rdpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_fire_i  (do_access && !cmd.wr),
    .arr_data_i (arr_data),
    .data_o     (rd_data),
    .valid_o    (rd_valid),
    .hit_o      (rd_hit)
  );

  // output enable and sleep gate the bus without a clock
  assign rdata_oe_o = rd_valid && !drv_en_ni && !sleep_i;
  assign rdata_o    = rdata_oe_o ? rd_data : '0;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int AW        = 6,
  parameter bit PIPELINED = 1'b0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_strobe_ni,
  input logic          ctl_strobe_ni,
  input logic          sleep_i,
  input logic          drv_en_ni,
  input logic          rdata_oe_o,
  input logic          chip_sel,
  input logic          do_load,
  input logic          do_step,
  input logic          do_access,
  input logic          do_write,
  input logic [AW-1:0] cur_addr
);
  a_r10_sleep_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !rdata_oe_o);

  a_r10_sleep_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !do_access);

  a_r11_oe_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_ni |-> !rdata_oe_o);

  a_r3_cpu_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !cpu_strobe_ni && chip_sel) |-> (do_access && !do_write));

  a_r9_desel_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && (!cpu_strobe_ni || !ctl_strobe_ni) && !chip_sel) |-> !do_access);

  a_r5_group_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !do_load |=> $stable(cur_addr[AW-1:2]));

  a_r6_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!do_load && !do_step) |=> $stable(cur_addr));

  if (PIPELINED) begin : g_pipe
    a_r11_write_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
      do_write |=> ##1 !rdata_oe_o);
  end else begin : g_flow
    a_r11_write_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
      do_write |=> !rdata_oe_o);
  end
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.AW(AW), .PIPELINED(PIPELINED)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_strobe_ni (cpu_strobe_ni),
  .ctl_strobe_ni (ctl_strobe_ni),
  .sleep_i       (sleep_i),
  .drv_en_ni     (drv_en_ni),
  .rdata_oe_o    (rdata_oe_o),
  .chip_sel      (chip_sel),
  .do_load       (do_load),
  .do_step       (do_step),
  .do_access     (do_access),
  .do_write      (do_write),
  .cur_addr      (cur_addr)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cpu_n = 1'b1, ctl_n = 1'b1, step_n = 1'b1;
  logic          ce_n = 1'b0, ce = 1'b1, ce2_n = 1'b0;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    sel_n = 4'hF;
  logic          oe_n = 1'b0, sleep = 1'b0;
  logic [35:0]   wdata = '0;
  logic [35:0]   f_data, p_data;
  logic          f_oe, p_oe;
  int            n_vec = 0, n_bad = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .cpu_strobe_ni(cpu_n), .ctl_strobe_ni(ctl_n), .burst_step_ni(step_n),
    .chip_en_ni(ce_n), .chip_en_i(ce), .chip_en2_ni(ce2_n),
    .all_wr_ni(gw_n), .lane_wr_ni(bwe_n), .lane_sel_ni(sel_n),
    .drv_en_ni(oe_n), .sleep_i(sleep), .wdata_i(wdata),
    .rdata_o(f_data), .rdata_oe_o(f_oe));

  sync_burst_sram #(.PIPELINED(1'b1), .INTERLEAVED(1'b1)) u_pipe (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .cpu_strobe_ni(cpu_n), .ctl_strobe_ni(ctl_n), .burst_step_ni(step_n),
    .chip_en_ni(ce_n), .chip_en_i(ce), .chip_en2_ni(ce2_n),
    .all_wr_ni(gw_n), .lane_wr_ni(bwe_n), .lane_sel_ni(sel_n),
    .drv_en_ni(oe_n), .sleep_i(sleep), .wdata_i(wdata),
    .rdata_o(p_data), .rdata_oe_o(p_oe));

  function automatic logic [35:0] pat(input int a);
    logic [8:0] b = 9'(a);
    return {b, b ^ 9'h155, b ^ 9'h0AA, ~b};
  endfunction

  task automatic chk(input string req, input logic [35:0] got, input logic [35:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    cpu_n = 1'b1; ctl_n = 1'b1; step_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; sel_n = 4'hF;
  endtask

  task automatic t_reset();
    chk("R12 flow oe after reset", 36'(f_oe), 36'd0);
    chk("R12 pipe oe after reset", 36'(p_oe), 36'd0);
    tick();
    chk("R12 no burst open", 36'(f_oe), 36'd0);
  endtask

  task automatic t_burst_write();
    ctl_n = 1'b0; addr = 6'd8; gw_n = 1'b0; wdata = pat(8);
    tick();
    chk("R11 write not driven", 36'(f_oe), 36'd0);
    ctl_n = 1'b1; step_n = 1'b0;
    for (int i = 9; i <= 11; i++) begin
      wdata = pat(i);
      tick();
      chk("R11 burst write not driven", 36'(f_oe), 36'd0);
    end
    idle();
  endtask

  task automatic t_burst_read();
    logic [35:0] f_exp [5];
    logic [35:0] p_exp [5];
    f_exp = '{pat(9), pat(10), pat(11), pat(8), pat(8)};
    p_exp = '{pat(9), pat(8), pat(11), pat(10), pat(10)};
    cpu_n = 1'b0; addr = 6'd9;
    tick();
    chk("R8 flow same-cycle data", f_data, f_exp[0]);
    chk("R8 flow oe", 36'(f_oe), 36'd1);
    chk("R8 pipe not yet driven", 36'(p_oe), 36'd0);
    cpu_n = 1'b1; step_n = 1'b0;
    for (int i = 1; i < 5; i++) begin
      if (i == 4) step_n = 1'b1;
      tick();
      chk(i == 4 ? "R6 hold repeats word" : "R5 linear step and wrap", f_data, f_exp[i]);
      chk("R7 interleaved order, R8 one-clock lag", p_data, p_exp[i-1]);
    end
    tick();
    chk("R7 pipe hold", p_data, p_exp[4]);
    idle();
  endtask

  task automatic t_lanes();
    logic [35:0] p20 = pat(20);
    ctl_n = 1'b0; addr = 6'd20; gw_n = 1'b0; wdata = p20;
    tick();
    gw_n = 1'b1; bwe_n = 1'b0; sel_n = 4'b1110; wdata = '1;
    tick();
    sel_n = 4'hF; wdata = '0;
    tick();
    chk("R2 all lanes masked is a read", f_data, {p20[35:9], 9'h1FF});
    chk("R2 read drives", 36'(f_oe), 36'd1);
    sel_n = 4'b0111;
    tick();
    idle();
    cpu_n = 1'b0;
    tick();
    chk("R1 lane a and lane d only", f_data, {9'h000, p20[26:9], 9'h1FF});
    idle();
  endtask

  task automatic t_cpu_then_write();
    cpu_n = 1'b0; addr = 6'd8; gw_n = 1'b0; wdata = '0;
    tick();
    chk("R3 processor strobe reads", f_data, pat(8));
    cpu_n = 1'b1; wdata = 36'h5_A5A5_A5A5;
    tick();
    chk("R4 write not driven", 36'(f_oe), 36'd0);
    idle();
    cpu_n = 1'b0;
    tick();
    chk("R4 write on following edge", f_data, 36'h5_A5A5_A5A5);
    idle();
  endtask

  task automatic t_oe();
    oe_n = 1'b1;
    #1;
    chk("R11 oe high undriven", 36'(f_oe), 36'd0);
    chk("R11 oe high data zero", f_data, 36'd0);
    oe_n = 1'b0;
    #1;
    chk("R11 oe low drives again", f_data, 36'h5_A5A5_A5A5);
  endtask

  task automatic t_deselect();
    ctl_n = 1'b0; addr = 6'd9; ce = 1'b0;
    tick();
    chk("R9 deselect undriven", 36'(f_oe), 36'd0);
    idle();
    ce = 1'b1; step_n = 1'b0;
    tick();
    chk("R9 no access after deselect", 36'(f_oe), 36'd0);
    idle();
  endtask

  task automatic t_sleep();
    cpu_n = 1'b0; addr = 6'd8;
    tick();
    chk("R10 read before sleep", 36'(f_oe), 36'd1);
    idle();
    sleep = 1'b1;
    #1;
    chk("R10 sleep undriven at once", 36'(f_oe), 36'd0);
    ctl_n = 1'b0; gw_n = 1'b0; wdata = '0;
    tick();
    chk("R10 sleep undriven", 36'(f_oe), 36'd0);
    idle();
    sleep = 1'b0;
    cpu_n = 1'b0;
    tick();
    chk("R10 sleep made no write", f_data, 36'h5_A5A5_A5A5);
    idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #3;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_burst_write();
    t_burst_read();
    t_lanes();
    t_cpu_then_write();
    t_oe();
    t_deselect();
    t_sleep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule